// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block sits in the fetch stage of a small core whose opcodes are 16 bits wide. For each decoded branch it gives the prefetch unit a predicted direction and a fetch target, using only the encoding and the current loop counter. No history is kept. A branch that jumps backward is assumed to close a loop and is predicted taken. A branch that jumps forward is predicted to fall through.

Branch targets are always even, so the lowest bit of the displacement holds no address information. The block reads that bit as a hint that reverses the default guess for one branch. A global input flips the meaning of the hint while code runs, which lets code laid out for a fall-through-only predictor run without being re-encoded. Decrement-and-branch loop instructions are predicted exactly from the counter. A legacy input restores the old behaviour, where every conditional branch is predicted not taken.

When the branch resolves, the pipeline returns the actual outcome together with the prediction that travelled with the branch. On a mismatch the block raises a one-cycle flush and gives the correct next PC.

Top module: `branch_dir_predict`

## Requirements
- R1: With legacy mode off, hint flip off and bit 0 of the displacement clear, a conditional branch with a negative displacement (bit 15 set) is predicted taken, and one with a non-negative displacement is predicted not taken.
- R2: When bit 0 of the displacement is 1 and hint flip is off, the direction from R1 is reversed for that branch.
- R3: When hint flip is 1, the hint is read as bit 0 inverted: a branch with bit 0 clear gets the reversed direction, and a branch with bit 0 set gets the default direction.
- R4: A loop branch, with legacy mode off, is predicted not taken when the 16-bit loop counter is 0 (it will decrement to 0xFFFF), and taken otherwise. The direction of the displacement and the hint bit have no effect on it.
- R5: With legacy mode on, every conditional branch is predicted not taken, including loop branches, whatever the displacement, hint or counter.
- R6: An unconditional branch is always predicted taken, in every mode and whatever the hint bit.
- R7: The predicted target is the branch PC plus 2 plus the sign-extended displacement, with bit 0 forced to 0.
- R8: One clock edge after a resolve with a wrong direction, or with both directions taken but the targets different, flush is 1 for one cycle. redirect_pc is then the resolved target if the branch was taken, and the branch PC plus 2 if it was not.
- R9: A resolve that matches its prediction, or a cycle with no resolve, leaves flush at 0 on the next cycle. Flush is 0 after reset.
- R10: pred_valid follows br_valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| legacy_mode | input | 1 | Predict all conditional branches not taken |
| hint_flip | input | 1 | Invert the meaning of displacement bit 0 |
| br_valid | input | 1 | A decoded branch is present |
| br_uncond | input | 1 | The branch is unconditional |
| br_loop | input | 1 | The branch is a decrement-and-branch loop |
| br_pc | input | 32 | Address of the branch opcode |
| br_disp | input | 16 | Signed displacement; bit 0 is the hint |
| loop_cnt | input | 16 | Loop counter value before the decrement |
| pred_valid | output | 1 | The prediction is valid |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted fetch target |
| res_valid | input | 1 | A branch resolved this cycle |
| res_pc | input | 32 | PC of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | 32 | Actual target |
| res_pred_taken | input | 1 | Direction predicted for this branch |
| res_pred_target | input | 32 | Target predicted for this branch |
| flush | output | 1 | One-cycle pulse that flushes the prefetch queue |
| redirect_pc | output | 32 | Correct next PC while flush is high |

## Verification
The assertions are checked on every cycle. They cover these rules: an unconditional branch is never predicted not taken, legacy mode never predicts a conditional branch taken, a loop branch with a zero counter is not taken, and the target is always even. They also check that flush follows a mismatched resolve and only a resolve. Only the bench scenarios can show the exact direction for each combination of sign, hint and flip setting, the target arithmetic, and the value of redirect_pc for each kind of mispredict.

// File: rtl/branch_dir_predict.sv
module branch_dir_predict #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          legacy_mode,
  input  logic          hint_flip,
  input  logic          br_valid,
  input  logic          br_uncond,
  input  logic          br_loop,
  input  logic [AW-1:0] br_pc,
  input  logic [DW-1:0] br_disp,
  input  logic [CW-1:0] loop_cnt,
  output logic          pred_valid,
  output logic          pred_taken,
  output logic [AW-1:0] pred_target,
  input  logic          res_valid,
  input  logic [AW-1:0] res_pc,
  input  logic          res_taken,
  input  logic [AW-1:0] res_target,
  input  logic          res_pred_taken,
  input  logic [AW-1:0] res_pred_target,
  output logic          flush,
  output logic [AW-1:0] redirect_pc
);
  localparam logic [AW-1:0] OP_BYTES = AW'(2);

  logic [AW-1:0] disp_ext, tgt_raw;
  logic          backward, hint, loop_exit, cond_taken;

  assign disp_ext  = {{(AW-DW){br_disp[DW-1]}}, br_disp};
  assign tgt_raw   = br_pc + OP_BYTES + disp_ext;
  assign backward  = br_disp[DW-1];
  assign hint      = br_disp[0] ^ hint_flip;
  assign loop_exit = (loop_cnt == '0);

  always_comb begin
    if (legacy_mode)  cond_taken = 1'b0;
    else if (br_loop) cond_taken = !loop_exit;
    else              cond_taken = backward ^ hint;
  end

  assign pred_valid  = br_valid;
  assign pred_taken  = br_uncond | cond_taken;
  assign pred_target = {tgt_raw[AW-1:1], 1'b0};

  logic dir_wrong, tgt_wrong, mispredict;
  assign dir_wrong  = res_taken != res_pred_taken;
  assign tgt_wrong  = res_taken && res_pred_taken && (res_target != res_pred_target);
  assign mispredict = res_valid && (dir_wrong || tgt_wrong);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush       <= 1'b0;
      redirect_pc <= '0;
    end else begin
      flush <= mispredict;
      if (mispredict) redirect_pc <= res_taken ? res_target : res_pc + OP_BYTES;
    end
  end
endmodule

// File: rtl/branch_dir_predict_chk.sv
module branch_dir_predict_chk #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          legacy_mode,
  input logic          br_valid,
  input logic          br_uncond,
  input logic          br_loop,
  input logic [CW-1:0] loop_cnt,
  input logic          pred_taken,
  input logic [AW-1:0] pred_target,
  input logic          res_valid,
  input logic          res_taken,
  input logic [AW-1:0] res_target,
  input logic          res_pred_taken,
  input logic [AW-1:0] res_pred_target,
  input logic          flush
);
  logic wrong;
  assign wrong = (res_taken != res_pred_taken) ||
                 (res_taken && res_target != res_pred_target);

  assert_uncond_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_uncond |-> pred_taken);
  assert_legacy_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && legacy_mode && !br_uncond |-> !pred_taken);
  assert_loop_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_loop && !br_uncond && !legacy_mode && loop_cnt == '0 |-> !pred_taken);
  assert_target_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> !pred_target[0]);
  assert_flush_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && wrong |=> flush);
  assert_no_spurious_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && wrong) |=> !flush);
endmodule

bind branch_dir_predict branch_dir_predict_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .br_valid(br_valid),
  .br_uncond(br_uncond), .br_loop(br_loop), .loop_cnt(loop_cnt),
  .pred_taken(pred_taken), .pred_target(pred_target), .res_valid(res_valid),
  .res_taken(res_taken), .res_target(res_target), .res_pred_taken(res_pred_taken),
  .res_pred_target(res_pred_target), .flush(flush)
);

// File: tb/sim_branch_dir_predict.sv
`timescale 1ns/1ps
module sim_branch_dir_predict;
  logic clk = 0, rst_n = 0;
  logic legacy_mode = 0, hint_flip = 0, br_valid = 0, br_uncond = 0, br_loop = 0;
  logic [31:0] br_pc = 32'h1000;
  logic [15:0] br_disp = 0, loop_cnt = 0;
  logic pred_valid, pred_taken, flush;
  logic [31:0] pred_target, redirect_pc;
  logic res_valid = 0, res_taken = 0, res_pred_taken = 0;
  logic [31:0] res_pc = 0, res_target = 0, res_pred_target = 0;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  branch_dir_predict u0 (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pred(input string tag, input logic unc, input logic lp,
                      input logic [15:0] d, input logic [15:0] c,
                      input logic exp_t, input logic [31:0] exp_tgt);
    @(negedge clk);
    br_valid = 1; br_uncond = unc; br_loop = lp; br_disp = d; loop_cnt = c;
    #1;
    chk({tag, " dir"}, {31'b0, pred_taken}, {31'b0, exp_t});
    chk({tag, " target R7"}, pred_target, exp_tgt);
    chk("R10 valid", {31'b0, pred_valid}, 32'd1);
  endtask

  task automatic resolve(input string tag, input logic t, input logic [31:0] tgt,
                         input logic pt, input logic [31:0] ptgt,
                         input logic exp_f, input logic [31:0] exp_pc);
    @(negedge clk);
    res_valid = 1; res_pc = 32'h2000; res_taken = t; res_target = tgt;
    res_pred_taken = pt; res_pred_target = ptgt;
    @(negedge clk);
    res_valid = 0;
    chk({tag, " flush"}, {31'b0, flush}, {31'b0, exp_f});
    if (exp_f) chk({tag, " redirect"}, redirect_pc, exp_pc);
    @(negedge clk);
    chk("R9 flush single cycle", {31'b0, flush}, 32'd0);
  endtask

  task automatic t_reset;
    #1 chk("R9 reset flush", {31'b0, flush}, 32'd0);
  endtask

  task automatic t_direction;
    hint_flip = 0; legacy_mode = 0;
    pred("R1 backward", 0, 0, 16'hFFF8, 0, 1, 32'h0FFA);
    pred("R1 forward",  0, 0, 16'h0010, 0, 0, 32'h1012);
    pred("R2 backward hinted", 0, 0, 16'hFFF9, 0, 0, 32'h0FFA);
    pred("R2 forward hinted",  0, 0, 16'h0011, 0, 1, 32'h1012);
  endtask

  task automatic t_flip;
    hint_flip = 1;
    pred("R3 backward plain",  0, 0, 16'hFFF8, 0, 0, 32'h0FFA);
    pred("R3 backward bit0",   0, 0, 16'hFFF9, 0, 1, 32'h0FFA);
    pred("R3 forward plain",   0, 0, 16'h0010, 0, 1, 32'h1012);
    hint_flip = 0;
  endtask

  task automatic t_loop;
    pred("R4 count 5",  0, 1, 16'hFFF0, 16'd5, 1, 32'h0FF2);
    pred("R4 count 1",  0, 1, 16'hFFF0, 16'd1, 1, 32'h0FF2);
    pred("R4 count 0",  0, 1, 16'hFFF0, 16'd0, 0, 32'h0FF2);
    pred("R4 count 0 hinted", 0, 1, 16'hFFF1, 16'd0, 0, 32'h0FF2);
    pred("R4 forward count 3", 0, 1, 16'h0020, 16'd3, 1, 32'h1022);
  endtask

  task automatic t_legacy;
    legacy_mode = 1;
    pred("R5 backward", 0, 0, 16'hFFF8, 0, 0, 32'h0FFA);
    pred("R5 hinted",   0, 0, 16'h0011, 0, 0, 32'h1012);
    pred("R5 loop",     0, 1, 16'hFFF0, 16'd5, 0, 32'h0FF2);
    pred("R6 uncond legacy", 1, 0, 16'h0010, 0, 1, 32'h1012);
    legacy_mode = 0;
  endtask

  task automatic t_uncond;
    pred("R6 uncond hinted fwd", 1, 0, 16'h0021, 0, 1, 32'h1022);
    hint_flip = 1;
    pred("R6 uncond flipped bwd", 1, 0, 16'hFFF8, 0, 1, 32'h0FFA);
    hint_flip = 0;
  endtask

  task automatic t_mispredict;
    resolve("R8 taken missed", 1, 32'h1F00, 0, 32'h0, 1, 32'h1F00);
    resolve("R8 fallthru missed", 0, 32'h1F00, 1, 32'h1F00, 1, 32'h2002);
    resolve("R8 target wrong", 1, 32'h1F04, 1, 32'h1F00, 1, 32'h1F04);
    resolve("R9 match taken", 1, 32'h1F00, 1, 32'h1F00, 0, 32'h0);
    resolve("R9 match not taken", 0, 32'h1F00, 0, 32'h1234, 0, 32'h0);
  endtask

  initial begin
    t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_direction;
    t_flip;
    t_loop;
    t_legacy;
    t_uncond;
    t_mispredict;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule